// File: doc/BRIEF.md
# Fabric Configuration Sequencer

This block lets a host load a programmable fabric over a parallel data port. When `start` is pulsed in idle, it reads a five-bit mode strap from the status word and checks that the fabric is powered. If both checks pass, it rewrites the low ten bits of a control word with the decoded bus width and clock-to-data ratio. It then walks the fabric through its reset, configuration and initialisation handshakes by watching the status pins.

While the configuration phase is open, the host streams bytes into the block. The block packs them into 32-bit words, with the first byte in the low lane. On `finish` it zero-fills any last partial word and closes the data port. After that it waits for the fabric to report either completion or an error. Every wait has a timer. The run ends with `done` high or with a nonzero `err_code`, and that result is held until the next accepted start.

Top module: `fabric_cfg_seq`

## Requirements
- R1: A start in idle while `pwr_ok` is 0 sets `err_code` to 1 on the next cycle. `cfg_ctrl` stays unchanged and `busy` stays 0.
- R2: The mode strap is `status_in[7:3]`. Values 3, 7, 11, 15 and 16 to 31 are rejected with `err_code` 2 and `busy` 0.
- R3: An accepted start writes `cfg_ctrl` as follows. Bit 0 is host mode (1). Bit 2 is the config pull (1). Bit 8 is the data enable (0). Bits [7:6] hold ratio-1. Bit 9 is 1 for a 32-bit width. All other bits are 0. Strap values with bit 3 clear give 16-bit width, and values with bit 3 set give 32-bit width. Bits [1:0] = 0 give ratio 1, and 1 gives ratio 2. Bits [1:0] = 2 give ratio 3 at 16-bit width and ratio 4 at 32-bit width. Strap bit 2 is ignored.
- R4: Reset phase: the block waits for `nstatus` low, then for `conf_done` low. Bit 2 of `cfg_ctrl` is then cleared. A timeout in either wait gives `err_code` 3.
- R5: Configuration phase: the block waits for `nstatus` high and then sets bit 8. A timeout gives `err_code` 4.
- R6: A byte offered while streaming with `nstatus` low is refused. No word is emitted, the run ends and `err_code` becomes 6.
- R7: Bytes are packed little-endian. `word_valid` pulses, with the packed `word_data`, on the cycle after every fourth byte.
- R8: `finish` while streaming, with no byte offered in the same cycle, does three things in one cycle. It emits any partial word with its upper bytes zero, clears bit 8, and emits nothing if the byte count is a multiple of four.
- R9: After the stream closes, the block waits for `conf_done` high or `nstatus` low. `nstatus` low gives `err_code` 6. A timeout gives `err_code` 5.
- R10: The block then waits for `init_done` high. When it arrives, bit 0 is cleared and `done` is set. A timeout gives `err_code` 7.
- R11: A wait times out after exactly `TIMEOUT_CYC` cycles in its phase.
- R12: `done` and `err_code` are cleared by an accepted start and otherwise hold. While busy they read 0. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a configuration run (idle only) |
| finish | input | 1 | End of the byte stream |
| status_in | input | 8 | Status word; bits [7:3] carry the mode strap |
| pwr_ok | input | 1 | Fabric power-on indication |
| nstatus | input | 1 | Fabric status pin (low = reset or error) |
| conf_done | input | 1 | Fabric configuration-complete pin |
| init_done | input | 1 | Fabric initialisation-complete pin |
| byte_valid | input | 1 | A stream byte is offered |
| byte_data | input | 8 | Stream byte |
| cfg_ctrl | output | 10 | Control word fields |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run succeeded |
| err_code | output | 3 | Last run's failure code (0 = none) |
| word_valid | output | 1 | Packed word strobe |
| word_data | output | 32 | Packed word to the fabric data port |

## Verification
A wrong phase shows up in the control word or `busy` on the very cycle the state moves. The config pull and data-enable bits mirror each handshake step, so a premature or missed transition is caught at once. A fault in the lane index or the pad logic stays hidden until the next `word_valid`, at most four bytes later. A timer that is off by one changes the cycle on which `err_code` appears. A cycle-accurate model compared on every clock exposes all of these within one cycle of their becoming visible.

// File: rtl/fabric_cfg_seq.sv
module fabric_cfg_seq #(
  parameter int unsigned TIMEOUT_CYC = 750_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        finish,
  input  logic [7:0]  status_in,
  input  logic        pwr_ok,
  input  logic        nstatus,
  input  logic        conf_done,
  input  logic        init_done,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  output logic [9:0]  cfg_ctrl,
  output logic        busy,
  output logic        done,
  output logic [2:0]  err_code,
  output logic        word_valid,
  output logic [31:0] word_data
);

  localparam logic [2:0] E_PWR = 3'd1, E_MSEL = 3'd2, E_RST = 3'd3, E_CFG = 3'd4,
                         E_STUCK = 3'd5, E_NST = 3'd6, E_INIT = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_RNS, S_RCD, S_CNS, S_STRM, S_WCD, S_WINIT} st_t;
  st_t st;

  logic [31:0] tmr;
  logic [1:0]  nb;
  logic [23:0] pk;
  logic [4:0]  mode;
  logic        mode_ok, wide;
  logic [1:0]  rm1;
  logic        expired;

  assign mode    = status_in[7:3];
  assign mode_ok = !mode[4] && (mode[1:0] != 2'b11);
  assign wide    = mode[3];
  assign rm1     = (mode[1:0] == 2'd2) ? (wide ? 2'd3 : 2'd2) : mode[1:0];
  assign expired = (tmr == TIMEOUT_CYC - 1);
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; nb <= '0; pk <= '0;
      cfg_ctrl <= '0; done <= 1'b0; err_code <= '0;
      word_valid <= 1'b0; word_data <= '0;
    end else begin
      word_valid <= 1'b0;
      tmr <= tmr + 32'd1;
      case (st)
        S_IDLE: if (start) begin
          done <= 1'b0; err_code <= '0;
          if (!pwr_ok) err_code <= E_PWR;
          else if (!mode_ok) err_code <= E_MSEL;
          else begin
            cfg_ctrl <= {wide, 1'b0, rm1, 3'b000, 1'b1, 1'b0, 1'b1};
            st <= S_RNS; tmr <= '0; nb <= '0; pk <= '0;
          end
        end
        S_RNS: if (!nstatus) begin st <= S_RCD; tmr <= '0; end
               else if (expired) begin st <= S_IDLE; err_code <= E_RST; end
        S_RCD: if (!conf_done) begin st <= S_CNS; tmr <= '0; cfg_ctrl[2] <= 1'b0; end
               else if (expired) begin st <= S_IDLE; err_code <= E_RST; end
        S_CNS: if (nstatus) begin st <= S_STRM; cfg_ctrl[8] <= 1'b1; end
               else if (expired) begin st <= S_IDLE; err_code <= E_CFG; end
        S_STRM: if (byte_valid) begin
          if (!nstatus) begin st <= S_IDLE; err_code <= E_NST; end
          else begin
            nb <= nb + 2'd1;
            if (nb == 2'd3) begin
              word_valid <= 1'b1; word_data <= {byte_data, pk}; pk <= '0;
            end else pk[{nb, 3'b000} +: 8] <= byte_data;
          end
        end else if (finish) begin
          if (nb != 2'd0) begin word_valid <= 1'b1; word_data <= {8'h00, pk}; end
          cfg_ctrl[8] <= 1'b0; st <= S_WCD; tmr <= '0;
        end
        S_WCD: if (!nstatus) begin st <= S_IDLE; err_code <= E_NST; end
               else if (conf_done) begin st <= S_WINIT; tmr <= '0; end
               else if (expired) begin st <= S_IDLE; err_code <= E_STUCK; end
        S_WINIT: if (init_done) begin st <= S_IDLE; cfg_ctrl[0] <= 1'b0; done <= 1'b1; end
                 else if (expired) begin st <= S_IDLE; err_code <= E_INIT; end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_power_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && !pwr_ok) |=> (err_code == E_PWR && !busy));
  a_r2_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && pwr_ok && (status_in[7] || status_in[4:3] == 2'b11))
      |=> (err_code == E_MSEL && !busy));
  a_r4_pull_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_ctrl[2]) |-> $past(!conf_done));
  a_r5_enable_after_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_ctrl[8]) |-> $past(nstatus));
  a_r6_refuse_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STRM && byte_valid && !nstatus) |=> (!word_valid && err_code == E_NST));
  a_r10_host_off_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !cfg_ctrl[0]);
  a_r12_clear_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && err_code == 3'd0));

endmodule

// File: tb/sim_fabric_cfg_seq.sv
`timescale 1ns/1ps
module sim_fabric_cfg_seq;
  localparam int TO = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, finish = 0, pwr_ok = 1, nstatus = 1, conf_done = 1, init_done = 0;
  logic byte_valid = 0;
  logic [7:0] byte_data = '0, status_in = '0;
  logic [9:0] cfg_ctrl;
  logic busy, done, word_valid;
  logic [2:0] err_code;
  logic [31:0] word_data;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  fabric_cfg_seq #(.TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .finish(finish), .status_in(status_in),
    .pwr_ok(pwr_ok), .nstatus(nstatus), .conf_done(conf_done), .init_done(init_done),
    .byte_valid(byte_valid), .byte_data(byte_data), .cfg_ctrl(cfg_ctrl), .busy(busy),
    .done(done), .err_code(err_code), .word_valid(word_valid), .word_data(word_data));

  function automatic bit m_valid(input int m);
    return (m < 16) && (m % 4 != 3);
  endfunction
  function automatic int m_ratio(input int m);
    case (m % 4)
      0: return 1;
      1: return 2;
      default: return (m >= 8) ? 4 : 3;
    endcase
  endfunction
  function automatic logic [9:0] exp_ctrl(input int m);
    return 10'(((m >= 8) ? 512 : 0) + ((m_ratio(m) - 1) * 64) + 5);
  endfunction

  // cycle-by-cycle reference model
  int ph = 0, age = 0;
  logic [9:0] m_ctrl = '0;
  logic m_done = 0, m_wv = 0;
  logic [2:0] m_err = '0;
  logic [31:0] m_wd = '0;
  logic [7:0] m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; age = 0; m_ctrl = '0; m_done = 0; m_err = '0; m_wv = 0; m_q.delete();
    end else begin
      m_wv = 0;
      age++;
      case (ph)
        0: if (start) begin
          m_done = 0; m_err = 0;
          if (!pwr_ok) m_err = 1;
          else if (!m_valid(int'(status_in[7:3]))) m_err = 2;
          else begin m_ctrl = exp_ctrl(int'(status_in[7:3])); ph = 1; age = 0; m_q.delete(); end
        end
        1: if (!nstatus) begin ph = 2; age = 0; end
           else if (age == TO) begin ph = 0; m_err = 3; end
        2: if (!conf_done) begin ph = 3; age = 0; m_ctrl[2] = 0; end
           else if (age == TO) begin ph = 0; m_err = 3; end
        3: if (nstatus) begin ph = 4; m_ctrl[8] = 1; end
           else if (age == TO) begin ph = 0; m_err = 4; end
        4: if (byte_valid) begin
          if (!nstatus) begin ph = 0; m_err = 6; end
          else begin
            m_q.push_back(byte_data);
            if (m_q.size() == 4) begin
              m_wv = 1; m_wd = {m_q[3], m_q[2], m_q[1], m_q[0]}; m_q.delete();
            end
          end
        end else if (finish) begin
          if (m_q.size() > 0) begin
            m_wd = 0;
            foreach (m_q[i]) m_wd = m_wd | (32'(m_q[i]) << (8 * i));
            m_wv = 1; m_q.delete();
          end
          m_ctrl[8] = 0; ph = 5; age = 0;
        end
        5: if (!nstatus) begin ph = 0; m_err = 6; end
           else if (conf_done) begin ph = 6; age = 0; end
           else if (age == TO) begin ph = 0; m_err = 5; end
        6: if (init_done) begin ph = 0; m_ctrl[0] = 0; m_done = 1; end
           else if (age == TO) begin ph = 0; m_err = 7; end
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    n_chk++;
    if (cfg_ctrl !== m_ctrl || busy !== (ph != 0) || done !== m_done || err_code !== m_err ||
        word_valid !== m_wv || (m_wv && word_data !== m_wd)) begin
      n_fail++;
      $display("FAIL R3/R7/R12 model t=%0t actual ctrl=%h busy=%b done=%b err=%0d wv=%b wd=%h expected ctrl=%h busy=%b done=%b err=%0d wv=%b wd=%h",
        $time, cfg_ctrl, busy, done, err_code, word_valid, word_data,
        m_ctrl, ph != 0, m_done, m_err, m_wv, m_wd);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic go(input int m);
    status_in = 8'(m << 3); start = 1; tick(); start = 0;
  endtask

  task automatic put(input logic [7:0] b);
    byte_valid = 1; byte_data = b; tick(); byte_valid = 0;
  endtask

  task automatic end_stream();
    finish = 1; tick(); finish = 0;
  endtask

  task automatic restore();
    nstatus = 1; conf_done = 1; init_done = 0; pwr_ok = 1; tick();
  endtask

  task automatic to_stream();
    go(9);
    chk("R12 err cleared on start", 32'(err_code), 0);
    nstatus = 0; tick();
    conf_done = 0; tick();
    chk("R4 pull released", 32'(cfg_ctrl), 32'h241);
    nstatus = 1; tick();
    chk("R5 data enable set", 32'(cfg_ctrl), 32'h341);
  endtask

  initial begin
    repeat (3) tick();
    chk("R3 reset ctrl", 32'(cfg_ctrl), 0);
    chk("R12 reset done/err", {done, err_code}, 0);
    rst_n = 1; tick();

    pwr_ok = 0; go(9);
    chk("R1 power-off err", 32'(err_code), 1);
    chk("R1 ctrl untouched", 32'(cfg_ctrl), 0);
    chk("R1 not busy", 32'(busy), 0);
    restore();

    for (int m = 0; m < 32; m++) begin
      go(m);
      if (!m_valid(m)) begin
        chk("R2 bad strap err", 32'(err_code), 2);
        chk("R2 not busy", 32'(busy), 0);
      end else begin
        chk("R3 ctrl decode", 32'(cfg_ctrl), 32'(exp_ctrl(m)));
        repeat (TO - 1) tick();
        chk("R11 still waiting", 32'(busy), 1);
        tick();
        chk("R4 reset timeout", 32'(err_code), 3);
      end
      tick();
    end

    to_stream();
    put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    chk("R7 word strobe", 32'(word_valid), 1);
    chk("R7 word data", word_data, 32'h44332211);
    put(8'h55); put(8'h66);
    end_stream();
    chk("R8 pad strobe", 32'(word_valid), 1);
    chk("R8 pad data", word_data, 32'h00006655);
    chk("R8 enable cleared", 32'(cfg_ctrl), 32'h241);
    conf_done = 1; tick();
    init_done = 1; tick();
    chk("R10 done", 32'(done), 1);
    chk("R10 host mode off", 32'(cfg_ctrl), 32'h240);
    init_done = 0; repeat (5) tick();
    chk("R12 done held", {done, err_code}, 32'h8);
    restore();

    go(9); nstatus = 0; tick(); conf_done = 0; tick();
    repeat (TO - 1) tick();
    chk("R11 config wait open", 32'(busy), 1);
    tick();
    chk("R5 config timeout", 32'(err_code), 4);
    restore();

    to_stream();
    put(8'hA1); put(8'hA2); put(8'hA3);
    nstatus = 0; put(8'hA4);
    chk("R6 no word on refusal", 32'(word_valid), 0);
    chk("R6 refusal err", 32'(err_code), 6);
    restore();

    to_stream();
    put(8'h01); put(8'h02); put(8'h03); put(8'h04);
    end_stream();
    chk("R8 no pad on full word", 32'(word_valid), 0);
    repeat (TO - 1) tick();
    chk("R11 stream-end wait open", 32'(busy), 1);
    tick();
    chk("R9 stuck timeout", 32'(err_code), 5);
    restore();

    to_stream();
    end_stream();
    nstatus = 0; tick();
    chk("R9 status error after stream", 32'(err_code), 6);
    restore();

    to_stream();
    end_stream();
    conf_done = 1; tick();
    repeat (TO) tick();
    chk("R10 init timeout", 32'(err_code), 7);
    restore();

    to_stream();
    put(8'hC1); put(8'hC2);
    go(0);
    chk("R12 start ignored busy", 32'(busy), 1);
    chk("R12 ctrl kept", 32'(cfg_ctrl), 32'h341);
    put(8'hC3); put(8'hC4);
    chk("R12 packing kept", word_data, 32'hC4C3C2C1);
    end_stream();
    nstatus = 0; tick();
    restore();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule